// File: doc/BRIEF.md
# SSI Absolute Encoder Position Reader

This block is the master side of a synchronous serial link to an absolute rotary encoder. It produces the serial clock itself. In each transfer it collects a 16-bit position word, most significant bit first, followed by one fault flag. Between transfers it holds the serial clock high for a mandatory idle gap, so that the encoder can re-arm before the next word.

A word whose fault flag is clear becomes the current position. The top eight bits of the position form the slice index, which gives 256 angular positions per turn. A one-cycle strobe tells the slice buffer logic that the index has moved. A word flagged as faulty is dropped, and the last good position stays on the outputs.

All timing is counted in system clock cycles. With a 50 MHz system clock and the default parameters, the serial clock runs at about 2 MHz, the idle gap is 20 µs, and a new word arrives about every 28 µs.

Top module: `ssi_pos_reader`

## Requirements
- R1: While reset is held and directly after it, `enc_sclk_o` is 1, `pos_o` is 0, `slice_o` is 0 and `slice_stb_o` is 0.
- R2: A transfer consists of exactly 17 serial clock cycles (17 falling and 17 rising edges). Within a transfer, each low phase and each high phase lasts `HALF_CYC` system cycles (12 by default).
- R3: The encoder presents a new bit after each falling edge of `enc_sclk_o`, and the reader captures `enc_data_i` at each rising edge. The first 16 bits captured are position bits 15 down to 0, in that order.
- R4: The 17th captured bit is the fault flag, where 1 means fault. A faulty word leaves `pos_o` and `slice_o` unchanged and raises no strobe.
- R5: A word with a clear fault flag is loaded into `pos_o` at the 17th rising edge of the serial clock, and `slice_o` always equals `pos_o[15:8]`. `pos_o` changes at no other time.
- R6: After the 17th rising edge, and also after reset, `enc_sclk_o` stays high for exactly `GAP_CYC` system cycles (1000 by default, which is 20 µs at 50 MHz) before the next falling edge.
- R7: `slice_stb_o` pulses for one cycle, together with the update of `pos_o`, exactly when a good word carries a slice index different from the one held before. A good word with the same index updates `pos_o` without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| enc_data_i | input | 1 | Serial data from the encoder (asynchronous, synchronized inside) |
| enc_sclk_o | output | 1 | Serial clock to the encoder; idles high |
| pos_o | output | 16 | Last good position word |
| slice_o | output | 8 | Slice index, the top eight bits of `pos_o` |
| slice_stb_o | output | 1 | One-cycle pulse when the slice index changes |

## Verification
The assertions assume the system clock is steady and that `GAP_CYC` is well above `2*HALF_CYC`, so that an idle gap can never be mistaken for an ordinary high phase. They also assume the encoder only changes its data line after a falling edge of the serial clock. The bench encoder model follows this: it changes its line only on falling edges and loads each new word during the idle gap. As a result, every captured bit has settled for most of a low phase plus the two synchronizer stages.

// File: rtl/ssi_pos_reader.sv
module ssi_pos_reader #(
  parameter int POS_W    = 16,
  parameter int SLICE_W  = 8,
  parameter int HALF_CYC = 12,
  parameter int GAP_CYC  = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enc_data_i,
  output logic               enc_sclk_o,
  output logic [POS_W-1:0]   pos_o,
  output logic [SLICE_W-1:0] slice_o,
  output logic               slice_stb_o
);

  localparam int NBITS   = POS_W + 1;
  localparam int CNT_MAX = (GAP_CYC > HALF_CYC) ? GAP_CYC : HALF_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int BW      = $clog2(NBITS + 1);

  typedef enum logic [1:0] {ST_GAP, ST_LOW, ST_HIGH} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bitn;
  logic [POS_W-1:0] shreg;
  logic [POS_W-1:0] pos_q;
  logic             sclk_q, stb_q;
  logic             din_m, din_s;

  wire half_done = (cnt == CW'(HALF_CYC - 1));
  wire gap_done  = (cnt == CW'(GAP_CYC - 1));
  wire last_bit  = (bitn == BW'(NBITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      din_m <= 1'b1;
      din_s <= 1'b1;
    end else begin
      din_m <= enc_data_i;
      din_s <= din_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_GAP;
      cnt    <= '0;
      bitn   <= '0;
      shreg  <= '0;
      pos_q  <= '0;
      sclk_q <= 1'b1;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      unique case (st)
        ST_GAP: begin
          if (gap_done) begin
            st     <= ST_LOW;
            cnt    <= '0;
            bitn   <= '0;
            sclk_q <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LOW: begin
          if (half_done) begin
            cnt    <= '0;
            sclk_q <= 1'b1;
            if (last_bit) begin
              st <= ST_GAP;
              if (!din_s) begin
                pos_q <= shreg;
                stb_q <= (shreg[POS_W-1 -: SLICE_W] != pos_q[POS_W-1 -: SLICE_W]);
              end
            end else begin
              st    <= ST_HIGH;
              shreg <= {shreg[POS_W-2:0], din_s};
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (half_done) begin
            st     <= ST_LOW;
            cnt    <= '0;
            sclk_q <= 1'b0;
            bitn   <= bitn + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign enc_sclk_o  = sclk_q;
  assign pos_o       = pos_q;
  assign slice_o     = pos_q[POS_W-1 -: SLICE_W];
  assign slice_stb_o = stb_q;

  logic [CW-1:0] lo_run, hi_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_run <= '0;
      hi_run <= '0;
    end else begin
      lo_run <= sclk_q ? '0 : ((&lo_run) ? lo_run : lo_run + 1'b1);
      hi_run <= sclk_q ? ((&hi_run) ? hi_run : hi_run + 1'b1) : '0;
    end
  end

  AST_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enc_sclk_o) |-> lo_run == CW'(HALF_CYC)) else $error("low phase width"); // R2
  AST_HIGH_OR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(enc_sclk_o) |-> (hi_run == CW'(HALF_CYC) || hi_run == CW'(GAP_CYC))) else $error("high phase or gap width"); // R6
  AST_POS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pos_o) |-> $rose(enc_sclk_o)) else $error("position moved off a rising edge"); // R5
  AST_STB_NEW_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
    slice_stb_o |-> slice_o != $past(slice_o)) else $error("strobe without slice change"); // R7
  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    slice_stb_o |=> !slice_stb_o) else $error("strobe wider than one cycle"); // R7
  AST_SLICE_MOVE_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (slice_o != $past(slice_o)) |-> slice_stb_o) else $error("slice moved silently"); // R7

endmodule

// File: tb/ssi_pos_reader_bench.sv
module ssi_pos_reader_bench;
  localparam int HALF = 12;
  localparam int GAP  = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b1;
  logic sclk;
  logic [15:0] pos;
  logic [7:0]  slice;
  logic        stb;

  ssi_pos_reader u_ssi_pos_reader (
    .clk(clk), .rst_n(rst_n), .enc_data_i(sdata), .enc_sclk_o(sclk),
    .pos_o(pos), .slice_o(slice), .slice_stb_o(stb)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [15:0] enc_word = 16'h0;
  logic        enc_err  = 1'b0;
  int idx = 0;
  int rises = 0;
  int stb_cnt = 0;
  int lo_run = 0, hi_run = 0, last_lo = 0, gap_meas = 0;

  always @(negedge sclk) begin
    if (idx < 16) sdata <= enc_word[15-idx];
    else          sdata <= enc_err;
    idx = (idx == 16) ? 0 : idx + 1;
  end

  always @(posedge sclk) rises++;

  always @(posedge clk) begin
    if (!rst_n) begin
      lo_run = 0; hi_run = 0;
    end else begin
      if (stb) stb_cnt++;
      if (sclk === 1'b1) begin
        if (lo_run != 0) last_lo = lo_run;
        lo_run = 0; hi_run++;
      end else begin
        if (hi_run > 2*HALF) gap_meas = hi_run;
        hi_run = 0; lo_run++;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [15:0] model_pos = 16'h0;

  task automatic xfer(input logic [15:0] word, input logic err, input string req);
    int r0, s0;
    logic exp_stb;
    @(negedge clk);
    enc_word = word;
    enc_err  = err;
    r0 = rises;
    s0 = stb_cnt;
    wait (rises == r0 + 17);
    repeat (4) @(negedge clk);
    exp_stb = !err && (word[15:8] != model_pos[15:8]);
    if (!err) model_pos = word;
    check(req, "pos_o", int'(pos), int'(model_pos));
    check("R5", "slice_o", int'(slice), int'(model_pos[15:8]));
    check("R7", "strobe count", stb_cnt - s0, int'(exp_stb));
    check("R2", "falls per transfer", idx, 0);
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    check("R1", "sclk in reset", int'(sclk), 1);
    check("R1", "pos in reset", int'(pos), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "sclk after reset", int'(sclk), 1);
    check("R1", "slice after reset", int'(slice), 0);
    check("R1", "strobe after reset", int'(stb), 0);
  endtask

  task automatic t_updates;
    xfer(16'h1234, 1'b0, "R5");
    xfer(16'h12FF, 1'b0, "R7");
    xfer(16'hABCD, 1'b1, "R4");
    xfer(16'hABCD, 1'b0, "R5");
  endtask

  task automatic t_patterns;
    xfer(16'h8001, 1'b0, "R3");
    xfer(16'h0000, 1'b0, "R3");
    xfer(16'hFFFF, 1'b1, "R4");
    xfer(16'h5A3C, 1'b0, "R3");
    xfer(16'h5AC3, 1'b0, "R7");
  endtask

  task automatic t_timing;
    xfer(16'hFFFF, 1'b0, "R5");
    check("R2", "low phase width", last_lo, HALF);
    check("R6", "idle gap width", gap_meas, GAP);
    repeat (GAP/2) @(negedge clk);
    check("R6", "sclk high in gap", int'(sclk), 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_updates();
        t_patterns();
        t_timing();
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule